// File: doc/BRIEF.md
# Tone-Pair Steering Qualifier

This block decides when a decoded tone pair counts as a dialled digit. A frequency detector upstream raises a "pair present" flag and offers a 4-bit digit code. The qualifier accepts the code only if the flag has stayed high for a programmable number of timebase ticks. It then holds the digit until the flag has stayed low for a second, independently programmed number of ticks. Because the two guard windows are separate, the hysteresis in time can be asymmetric. Short bursts (talk-off) are rejected, and short dropouts inside a real tone are bridged.

The accepted code goes into an output register. A configurable number of clocks later, a "digit held" level rises together with a one-clock "new digit" pulse, so downstream status logic sees stable data before the flag moves. The timebase tick is a one-clock strobe, typically 1 ms, supplied by the surrounding chip. Frequency estimation and analog filtering belong to other blocks.

Top module: `tone_steer_qual`

## Requirements
- R1: After a synchronous active-low reset, `digit_code` is 0, `digit_held` is 0 and `digit_new` is 0.
- R2: `digit_code` takes the value on `pair_code` in the clock where `pair_valid` has been high continuously across PRES_TICKS tick strobes. A tick in the same clock as the rising edge of `pair_valid` is not counted.
- R3: A presence lasting fewer than PRES_TICKS ticks leaves `digit_code`, `digit_held` and `digit_new` unchanged.
- R4: Any clock with `pair_valid` low during present qualification discards the ticks counted so far. Two bursts of PRES_TICKS-1 ticks separated by a one-clock gap are rejected.
- R5: Once a digit is registered, changes on `pair_code` do not alter `digit_code` until the next validated presence.
- R6: An absence of fewer than ABS_TICKS ticks while a digit is held keeps `digit_held` high, produces no `digit_new` pulse, and leaves `digit_code` unchanged.
- R7: After `pair_valid` has stayed low across ABS_TICKS ticks, `digit_held` falls. `digit_code` keeps the last digit until the next validated one.
- R8: `digit_held` and `digit_new` rise exactly SETTLE_CLKS clocks after the clock that updates `digit_code`. `digit_code` never changes while `digit_held` is high.
- R9: `digit_new` is high for exactly one clock per validated digit and coincides with the rise of `digit_held`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock timebase strobe for the guard counters |
| pair_valid | input | 1 | Upstream detector sees a valid tone pair |
| pair_code | input | 4 | Decoded digit code offered by the detector |
| digit_code | output | 4 | Registered digit |
| digit_held | output | 1 | High while a validated digit is held |
| digit_new | output | 1 | One-clock pulse per newly registered digit |

## Verification
The bound checker watches every clock for the following:
- `digit_new` and the rise of `digit_held` always coincide.
- The pulse never lasts two clocks.
- `digit_code` moves only while `digit_held` is low.
- `digit_held` falls only after a low `pair_valid`.
- The held level is never set in the idle state.

Whether a burst was long enough, whether a dropout was bridged, and which code value was captured all depend on tick counts over many clocks. Only the bench scenarios show these, through the scoreboard of expected digits and the exact-boundary, glitch and dropout cases.

// File: rtl/steer_pkg.sv
// Shared types for the tone-pair steering qualifier.
package steer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_QUAL_P = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_QUAL_A = 2'd3
    } steer_state_t;
endpackage

// File: rtl/guard_timer.sv
// Tick counter shared by both guard windows.
// Assumes the controller clears it on every state change, so one counter serves both windows.
module guard_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // count ticks, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/steer_fsm.sv
// Four-state qualifier: idle, present-qualify, active, absent-qualify.
// Assumes pair_valid is already synchronous to clk.
module steer_fsm
    import steer_pkg::*;
#(
    parameter int PRES_TICKS = 40,
    parameter int ABS_TICKS  = 40,
    parameter int W          = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pair_valid,
    input  logic [W-1:0] cnt,
    output logic         clr,
    output logic         inc,
    output logic         latch_evt,
    output logic         release_evt,
    output steer_state_t state
);
    localparam logic [W-1:0] PRES_LAST = W'(PRES_TICKS - 1);
    localparam logic [W-1:0] ABS_LAST  = W'(ABS_TICKS - 1);

    steer_state_t nxt;

    // next state and timer control
    always_comb begin
        nxt         = state;
        clr         = 1'b0;
        inc         = 1'b0;
        latch_evt   = 1'b0;
        release_evt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pair_valid) begin
                    nxt = ST_QUAL_P;
                    clr = 1'b1;
                end
            end
            ST_QUAL_P: begin
                if (!pair_valid) begin
                    nxt = ST_IDLE;
                    clr = 1'b1;
                end else if (tick) begin
                    if (cnt == PRES_LAST) begin
                        nxt       = ST_ACTIVE;
                        clr       = 1'b1;
                        latch_evt = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
            end
            ST_ACTIVE: begin
                if (!pair_valid) begin
                    nxt = ST_QUAL_A;
                    clr = 1'b1;
                end
            end
            ST_QUAL_A: begin
                if (pair_valid) begin
                    nxt = ST_ACTIVE;
                    clr = 1'b1;
                end else if (tick) begin
                    if (cnt == ABS_LAST) begin
                        nxt         = ST_IDLE;
                        clr         = 1'b1;
                        release_evt = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/settle_pipe.sv
// Delays the latch event by SETTLE_CLKS clocks, then raises the held level and a one-clock pulse.
// Assumes release never coincides with a fresh latch; a release cancels any pending event.
module settle_pipe #(
    parameter int SETTLE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_evt,
    input  logic cancel,
    output logic held,
    output logic pulse
);
    logic [SETTLE_CLKS-1:0] sr;

    generate
        if (SETTLE_CLKS == 1) begin : g_one
            // single-stage delay
            always_ff @(posedge clk) begin
                if (!rst_n || cancel) sr <= '0;
                else                  sr <= latch_evt;
            end
        end else begin : g_multi
            // multi-stage delay line
            always_ff @(posedge clk) begin
                if (!rst_n || cancel) sr <= '0;
                else                  sr <= {sr[SETTLE_CLKS-2:0], latch_evt};
            end
        end
    endgenerate

    // held level and new-digit pulse
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            held  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= sr[SETTLE_CLKS-1];
            if (sr[SETTLE_CLKS-1]) held <= 1'b1;
        end
    end
endmodule

// File: rtl/tone_steer_qual.sv
// Top of the steering qualifier: guard timer, controller, code register and settle pipe.
// Assumes tick is a one-clock strobe and PRES_TICKS, ABS_TICKS, SETTLE_CLKS are all at least 1.
module tone_steer_qual
    import steer_pkg::*;
#(
    parameter int PRES_TICKS  = 40,
    parameter int ABS_TICKS   = 40,
    parameter int SETTLE_CLKS = 2,
    parameter int CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pair_valid,
    input  logic [CODE_W-1:0] pair_code,
    output logic [CODE_W-1:0] digit_code,
    output logic              digit_held,
    output logic              digit_new
);
    localparam int MAXT = (PRES_TICKS > ABS_TICKS) ? PRES_TICKS : ABS_TICKS;
    localparam int W    = $clog2(MAXT + 1);

    logic         clr, inc, latch_evt, release_evt;
    logic [W-1:0] cnt;
    steer_state_t state_q;

    guard_timer #(.W(W)) timer_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .cnt(cnt)
    );

    steer_fsm #(.PRES_TICKS(PRES_TICKS), .ABS_TICKS(ABS_TICKS), .W(W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pair_valid(pair_valid), .cnt(cnt),
        .clr(clr), .inc(inc), .latch_evt(latch_evt), .release_evt(release_evt),
        .state(state_q)
    );

    // capture the code when presence is validated
    always_ff @(posedge clk) begin
        if (!rst_n)         digit_code <= '0;
        else if (latch_evt) digit_code <= pair_code;
    end

    settle_pipe #(.SETTLE_CLKS(SETTLE_CLKS)) settle_i (
        .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .cancel(release_evt),
        .held(digit_held), .pulse(digit_new)
    );
endmodule

// File: rtl/steer_qual_chk.sv
// Cycle-level properties of the steering qualifier, bound to the top.
module steer_qual_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pair_valid,
    input logic [CODE_W-1:0] digit_code,
    input logic              digit_held,
    input logic              digit_new,
    input logic [1:0]        state
);
    // R9
    pulse_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_new |-> $rose(digit_held));
    // R9
    rise_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(digit_held) |-> digit_new);
    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_new |=> !digit_new);
    // R8
    code_settles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digit_code) |-> !digit_held);
    // R7
    fall_after_absence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(digit_held) |-> !$past(pair_valid));
    // R1
    idle_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0) |-> !digit_held);
endmodule

bind tone_steer_qual steer_qual_chk #(.CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .digit_code(digit_code),
    .digit_held(digit_held), .digit_new(digit_new), .state(state_q)
);

// File: tb/tone_steer_qual_tb_top.sv
module tone_steer_qual_tb_top;
    localparam int PRES   = 5;
    localparam int ABSN   = 3;
    localparam int SETTLE = 3;
    localparam int TDIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pair_valid = 1'b0;
    logic [3:0] pair_code = 4'h0;
    logic [3:0] digit_code;
    logic       digit_held, digit_new;

    int total = 0;
    int bad = 0;
    int phase = 0;
    int npulse = 0;
    int nexp = 0;
    logic [3:0] expq[$];
    logic [3:0] prev_code = 4'h0;
    logic       prev_new = 1'b0;

    always #4 clk = ~clk;

    tone_steer_qual #(.PRES_TICKS(PRES), .ABS_TICKS(ABSN), .SETTLE_CLKS(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pair_valid(pair_valid), .pair_code(pair_code),
        .digit_code(digit_code), .digit_held(digit_held), .digit_new(digit_new)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] c);
        @(negedge clk);
        pair_valid = v;
        pair_code  = c;
        tick       = (phase == TDIV - 1);
        phase      = (phase + 1) % TDIV;
    endtask

    task automatic hold(input logic v, input logic [3:0] c, input int nticks);
        for (int i = 0; i < nticks * TDIV; i++) step(v, c);
    endtask

    task automatic realign();
        while (phase != 0) step(1'b0, 4'h0);
    endtask

    task automatic expect_digit(input logic [3:0] c);
        expq.push_back(c);
        nexp++;
    endtask

    // monitor: pops expected digits on each new-digit pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (digit_new) begin
                npulse++;
                chk(!prev_new, "R9 pulse longer than one clock", 1, 0);
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 unexpected digit", digit_code, -1);
                end else begin
                    logic [3:0] e;
                    e = expq.pop_front();
                    chk(digit_code == e, "R2 latched code", digit_code, e);
                    chk(prev_code == e, "R8 code settled before flag", prev_code, e);
                    chk(digit_held == 1'b1, "R8 held rises with pulse", digit_held, 1);
                end
            end
            prev_code <= digit_code;
            prev_new  <= digit_new;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(digit_code == 4'h0, "R1 reset code", digit_code, 0);
        chk(digit_held == 1'b0, "R1 reset held", digit_held, 0);
        chk(digit_new == 1'b0, "R1 reset pulse", digit_new, 0);
        rst_n = 1'b1;
        hold(1'b0, 4'h0, 2);

        // R2: a long burst is accepted
        expect_digit(4'h7);
        hold(1'b1, 4'h7, PRES + 2);
        chk(digit_held == 1'b1, "R2 held after long burst", digit_held, 1);
        chk(digit_code == 4'h7, "R2 code after long burst", digit_code, 7);
        hold(1'b0, 4'h7, ABSN + 1);
        chk(digit_held == 1'b0, "R7 release after absence", digit_held, 0);
        chk(digit_code == 4'h7, "R7 code held through pause", digit_code, 7);

        // R3: a burst one tick short is rejected
        hold(1'b1, 4'h3, PRES - 1);
        hold(1'b0, 4'h3, ABSN + 1);
        chk(digit_code == 4'h7, "R3 short burst code", digit_code, 7);
        chk(digit_held == 1'b0, "R3 short burst held", digit_held, 0);
        chk(npulse == nexp, "R3 short burst pulses", npulse, nexp);

        // R2: exactly PRES ticks is accepted
        expect_digit(4'hC);
        hold(1'b1, 4'hC, PRES);
        hold(1'b0, 4'hC, ABSN + 1);
        chk(digit_code == 4'hC, "R2 exact boundary code", digit_code, 12);
        chk(npulse == nexp, "R9 exact boundary pulses", npulse, nexp);

        // R4: a one-clock gap restarts the present timer
        hold(1'b1, 4'h5, PRES - 1);
        step(1'b0, 4'h5);
        for (int i = 0; i < (PRES - 1) * TDIV; i++) step(1'b1, 4'h5);
        realign();
        hold(1'b0, 4'h5, ABSN + 1);
        chk(digit_code == 4'hC, "R4 glitch restart code", digit_code, 12);
        chk(npulse == nexp, "R4 glitch restart pulses", npulse, nexp);

        // R5, R6: code changes and a short dropout while held
        expect_digit(4'hA);
        hold(1'b1, 4'hA, PRES + 1);
        hold(1'b1, 4'h2, 1);
        chk(digit_code == 4'hA, "R5 code change ignored", digit_code, 10);
        hold(1'b0, 4'h2, ABSN - 1);
        chk(digit_held == 1'b1, "R6 held through dropout", digit_held, 1);
        hold(1'b1, 4'hA, 2);
        chk(digit_held == 1'b1, "R6 held after dropout", digit_held, 1);
        chk(digit_code == 4'hA, "R6 code kept after dropout", digit_code, 10);
        chk(npulse == nexp, "R6 no extra pulse", npulse, nexp);
        hold(1'b0, 4'hA, ABSN + 1);
        chk(digit_held == 1'b0, "R7 release after dropout case", digit_held, 0);

        // next digit after a pause, code zero
        expect_digit(4'h0);
        hold(1'b1, 4'h0, PRES + 2);
        chk(digit_code == 4'h0, "R2 digit after pause", digit_code, 0);
        hold(1'b0, 4'h0, ABSN + 2);
        chk(npulse == nexp, "R9 total pulses", npulse, nexp);
        chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule